// File: doc/BRIEF.md
# Fractional Serial Bit-Clock Generator

This block derives the serial clock of an SPI-style master from a fast functional clock. The speed is set by an 8-bit rate field that works as a multiplier out of 512: the serial clock runs at the functional clock times the field value divided by 512. The field is meant to hold a power of two. The all-ones code stands for 256, which gives the fastest rate of half the functional clock. A field of 1 gives the slowest rate, the functional clock divided by 512, and a field of 0 is treated as 1 so the clock never stalls. Any other value also works and gives an evenly spread fractional rate.

The surrounding controller supplies the rate field, the clock polarity and the clock phase of whichever device is currently selected, plus a run request. While run is low the serial clock rests at the polarity level. While run is high, a 9-bit accumulator adds the effective rate every cycle, and each carry out of its 8-bit residue moves the clock by one half period. Alongside the clock the block gives the shifter one-cycle strobes for the leading edge (the clock leaves its rest level) and the trailing edge (it returns to it). It also gives those same strobes relabelled as sample and shift according to the phase setting. Chip-select timing and the data shifter live elsewhere.

The edge sequencer has three states. ST_IDLE is not running. ST_REST is running with the clock at its rest level. ST_ACTIVE is running with the clock at the opposite level. The transitions are as follows. Run low sends every state to ST_IDLE. In ST_IDLE or ST_REST, run high moves to ST_ACTIVE on a carry (the leading edge) and otherwise stays in or enters ST_REST. In ST_ACTIVE a carry moves back to ST_REST (the trailing edge).

Top module: `sclk_frac_gen`

## Requirements
- R1: After reset, and before run is first raised, sclk equals cpol, and lead_stb, trail_stb, sample_stb and shift_stb are 0.
- R2: While run is low, sclk equals cpol and all strobes are 0 from the next cycle on. The accumulator is cleared, so every start from rest behaves as if it were the first.
- R3: Count the rising clock edges from the first edge at which run is sampled high as k = 1, 2, and so on. Let e be the effective rate. A half-period edge happens at edge k exactly when floor(k*e/256) exceeds floor((k-1)*e/256). For a power-of-two field f this gives one edge every 256/f cycles.
- R4: A rate field of 8'hFF acts as e = 256: sclk changes at every rising edge while running, which is half the functional clock rate.
- R5: A rate field of 8'h00 acts as e = 1: one half-period edge every 256 cycles.
- R6: Half-period edges alternate between leading and trailing, and the first edge after a start is a leading edge. After edge k, sclk equals cpol XOR the parity of floor(k*e/256).
- R7: lead_stb is high for exactly the one cycle after a leading edge, and trail_stb for exactly the one cycle after a trailing edge. They are never high together.
- R8: With cpha = 0, sample_stb follows lead_stb and shift_stb follows trail_stb. With cpha = 1 the two roles swap.
- R9: The rest level of sclk is cpol. During lead_stb, sclk is at NOT cpol, and during trail_stb it is at cpol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Serial clock enable for the current transfer |
| rate_field | input | 8 | Rate multiplier out of 512; 0 acts as 1, 8'hFF as 256 |
| cpol | input | 1 | Rest level of sclk for the selected device |
| cpha | input | 1 | 0: sample on leading edges; 1: sample on trailing edges |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse after a leading edge |
| trail_stb | output | 1 | One-cycle pulse after a trailing edge |
| sample_stb | output | 1 | Edge at which the shifter captures input data |
| shift_stb | output | 1 | Edge at which the shifter launches output data |

## Verification
The hardest case to reach from the ports is a non-power-of-two field whose leftover residue shifts the first edge of the next transfer. The edge spacing then varies from one half period to the next, and any residue left over from an earlier run would shift the whole pattern by a fraction of a period. The stimulus therefore sweeps every one of the 256 field values back to back, with run dropped between them and polarity and phase cycled through all four pairs. Each rising edge is compared against the floor-quotient formula, and a leftover residue shows up as a displaced first edge.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    // Edge sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REST   = 2'd1,
        ST_ACTIVE = 2'd2
    } clk_state_e;

endpackage

// File: rtl/sclk_rate_accum.sv
module sclk_rate_accum #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_field,
    output logic              tick
);
    localparam int ACC_W = RATE_W + 1;
    localparam logic [ACC_W-1:0] FULL_SCALE = ACC_W'(1) << RATE_W;

    logic [RATE_W-1:0] resid_q;
    logic [ACC_W-1:0]  step;
    logic [ACC_W-1:0]  sum;

    // Zero maps to the slowest step, all-ones to the full-scale step
    always_comb begin
        if (rate_field == '0)
            step = ACC_W'(1);
        else if (&rate_field)
            step = FULL_SCALE;
        else
            step = {1'b0, rate_field};
        sum  = {1'b0, resid_q} + step;
        tick = run & sum[RATE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resid_q <= '0;
        else if (!run)
            resid_q <= '0;
        else
            resid_q <= sum[RATE_W-1:0];
    end
endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm
    import sclk_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic cpol,
    output logic sclk,
    output logic lead_stb,
    output logic trail_stb
);
    clk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_REST: state_d = tick ? ST_ACTIVE : ST_REST;
                ST_ACTIVE:        state_d = tick ? ST_REST : ST_ACTIVE;
                default:          state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Edge strobes, aligned with the cycle in which sclk has moved
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            lead_stb  <= run && tick && (state_q != ST_ACTIVE);
            trail_stb <= run && tick && (state_q == ST_ACTIVE);
        end
    end

    assign sclk = cpol ^ (state_q == ST_ACTIVE);
endmodule

// File: rtl/sclk_edge_role.sv
module sclk_edge_role (
    input  logic cpha,
    input  logic lead_stb,
    input  logic trail_stb,
    output logic sample_stb,
    output logic shift_stb
);
    always_comb begin
        if (cpha) begin
            sample_stb = trail_stb;
            shift_stb  = lead_stb;
        end else begin
            sample_stb = lead_stb;
            shift_stb  = trail_stb;
        end
    end
endmodule

// File: rtl/sclk_frac_gen.sv
module sclk_frac_gen #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_field,
    input  logic              cpol,
    input  logic              cpha,
    output logic              sclk,
    output logic              lead_stb,
    output logic              trail_stb,
    output logic              sample_stb,
    output logic              shift_stb
);
    logic tick;

    sclk_rate_accum #(.RATE_W(RATE_W)) i_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .rate_field (rate_field),
        .tick       (tick)
    );

    sclk_phase_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .cpol      (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    sclk_edge_role i_role (
        .cpha       (cpha),
        .lead_stb   (lead_stb),
        .trail_stb  (trail_stb),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb)
    );
endmodule

// File: rtl/sclk_frac_gen_chk.sv
module sclk_frac_gen_chk #(
    parameter int RATE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [RATE_W-1:0] rate_field,
    input logic              cpol,
    input logic              sclk,
    input logic              lead_stb,
    input logic              trail_stb
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!lead_stb && !trail_stb && sclk == cpol));

    p_full_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (&rate_field)) |=> (lead_stb || trail_stb));

    p_lead_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |=> !lead_stb);

    p_trail_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |=> !trail_stb);

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    p_lead_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != cpol));

    p_trail_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk == cpol));
endmodule

bind sclk_frac_gen sclk_frac_gen_chk #(.RATE_W(RATE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .rate_field (rate_field),
    .cpol       (cpol),
    .sclk       (sclk),
    .lead_stb   (lead_stb),
    .trail_stb  (trail_stb)
);

// File: tb/test_sclk_frac_gen.sv
module test_sclk_frac_gen;
    localparam int RUN_LEN = 520;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] rate_field = 8'd0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       sclk, lead_stb, trail_stb, sample_stb, shift_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sclk_frac_gen i_sclk_frac_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .rate_field (rate_field),
        .cpol       (cpol),
        .cpha       (cpha),
        .sclk       (sclk),
        .lead_stb   (lead_stb),
        .trail_stb  (trail_stb),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (rate=%0d cpol=%0b cpha=%0b t=%0t)",
                     tag, act, exp, rate_field, cpol, cpha, $time);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 sclk", sclk, 0);
        chk("R1 strobes", {lead_stb, trail_stb, sample_stb, shift_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sclk after release", sclk, 0);
        chk("R1 strobes after release", {lead_stb, trail_stb, sample_stb, shift_stb}, 0);

        for (int r = 0; r < 256; r++) begin
            int eff;
            rate_field = r[7:0];
            cpol = r[0];
            cpha = r[1];
            eff = (r == 0) ? 1 : ((r == 255) ? 256 : r);
            @(negedge clk);
            // R9: rest level while idle follows polarity
            chk("R9 rest level", sclk, cpol);
            run = 1'b1;
            for (int k = 1; k <= RUN_LEN; k++) begin
                int n_now, n_prev, edge_now, exp_lead, exp_trail;
                @(negedge clk);
                n_now  = (k * eff) / 256;
                n_prev = ((k - 1) * eff) / 256;
                edge_now  = (n_now != n_prev) ? 1 : 0;
                exp_lead  = edge_now & (n_now % 2);
                exp_trail = edge_now & (1 - (n_now % 2));
                if (r == 0)
                    chk("R5 sclk", sclk, cpol ^ (n_now % 2));
                else if (r == 255)
                    chk("R4 sclk", sclk, cpol ^ (n_now % 2));
                else
                    chk("R3/R6 sclk", sclk, cpol ^ (n_now % 2));
                chk("R7 lead_stb", lead_stb, exp_lead);
                chk("R7 trail_stb", trail_stb, exp_trail);
                chk("R8 sample_stb", sample_stb, cpha ? exp_trail : exp_lead);
                chk("R8 shift_stb", shift_stb, cpha ? exp_lead : exp_trail);
            end
            run = 1'b0;
            @(negedge clk);
            // R2: stopped clock rests, strobes quiet
            chk("R2 sclk stopped", sclk, cpol);
            chk("R2 strobes stopped", {lead_stb, trail_stb, sample_stb, shift_stb}, 0);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule